// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects on-chip logic to an external 128K x 16 asynchronous static RAM that has byte lanes. On-chip logic raises a request that carries a word address, write data, two byte-enable bits and a read/write flag. It holds the request until the controller returns a single-cycle acknowledge. A read also returns registered data together with a one-cycle valid pulse.

On the memory side the controller drives the following pins:
- the address bus;
- a low-active and a high-active chip enable;
- the write enable and the output enable;
- one low-active strobe per byte lane.

The bidirectional data bus is split into an output value, an output-enable and an input value, so the pad ring decides how to build the tri-state buffer.

Every analog timing limit of the memory is a nanosecond parameter. Each one is converted to a whole number of system clock cycles, rounded up, from a clock-period parameter. Address changes happen only while the write enable is high. The controller drives the data bus only while the write enable is low. Bus turnaround cycles keep the memory's outputs and the controller's drivers from overlapping.

Top module: `async_sram_ctl`

## Requirements
- R1: After reset and whenever no access is in progress, the low-active chip enable is 1, the high-active chip enable is 0, write enable and output enable are 1, the data-bus enable is 0, and acknowledge and read-valid are 0.
- R2: A read holds the chip selected, write enable high and output enable low for exactly RD_CYC cycles. RD_CYC is the ceiling of the largest of the read-cycle, address-access and output-enable-access times divided by the clock period. The acknowledge appears RD_CYC+1 rising edges after the edge that accepts the request.
- R3: The read data is captured at the end of the read window. It is presented with read-valid high for exactly one cycle, in the same cycle as the acknowledge. Read-valid is never raised for a write.
- R4: During a write, output enable stays high. The data bus is driven only while write enable is low. Write enable is low for exactly WP_CYC consecutive cycles, where WP_CYC is the ceiling of the largest of the write-cycle, address-valid-to-end, pulse-width, byte-strobe-to-end and data-setup times divided by the clock period.
- R5: A write first holds the chip selected with write enable and output enable high and the bus undriven for exactly SU_CYC cycles, the ceiling of the output-float time. Its acknowledge appears SU_CYC+WP_CYC+2 rising edges after the accepting edge.
- R6: The address bus changes only in a cycle in which write enable is high and was high in the previous cycle.
- R7: The cycle after write enable rises has the chip deselected and the bus undriven. This gives at least one idle cycle before any following access.
- R8: Byte-enable bit 0 controls data bits 7:0 through the lower strobe, and bit 1 controls bits 15:8 through the upper strobe. While the chip is selected, a strobe is low exactly when its enable bit is 1. A disabled lane is left unchanged by a write and reads back as zero.
- R9: A request is accepted only when the controller is idle and the acknowledge is low. Each acknowledge lasts exactly one cycle.
- R10: Each derived cycle count is checked at elaboration to be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, held until acknowledged |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (17) | Word address |
| reqWdata | input | DATA_W (16) | Write data |
| reqBe | input | 2 | Byte enables, bit 0 = low byte |
| ack | output | 1 | One-cycle completion pulse |
| rdValid | output | 1 | One-cycle read-data-valid pulse |
| rdData | output | DATA_W (16) | Registered read data |
| memAddr | output | ADDR_W (17) | Memory address bus |
| memCeN | output | 1 | Chip enable, active low |
| memCe2 | output | 1 | Chip enable, active high |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memLbN | output | 1 | Lower byte strobe, active low |
| memUbN | output | 1 | Upper byte strobe, active low |
| dqOut | output | DATA_W (16) | Data driven toward the memory |
| dqOe | output | 1 | Data bus drive enable |
| dqIn | input | DATA_W (16) | Data returned from the memory |

## Verification
Random mixes of reads and writes go to a small pool of addresses, so that reads often hit locations written earlier with a different byte-enable pattern. This separates correct lane merging from whole-word writes. Directed cases exercise the lowest and highest addresses, a write with no lanes enabled, and back-to-back write-then-read and read-then-write pairs. The back-to-back pairs separate a correct turnaround from one that drives the bus while the memory still outputs data. For each access, a memory model at the pins counts the write-enable-low cycles, the setup cycles and the output-enable cycles, and flags any address movement while write enable is low.

// File: rtl/async_sram_ctl_pkg.sv
package async_sram_ctl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_WSETUP,
    S_WPULSE,
    S_WEND
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // latch request fields this cycle
    logic capture;   // sample returned data at this edge
    logic chipSel;   // registered: both chip enables active
    logic readEn;    // registered: output enable active
    logic writeEn;   // registered: write enable active
    logic driveBus;  // registered: controller owns the data bus
  } ctlStrobe_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/async_sram_ctl_fsm.sv
module async_sram_ctl_fsm
  import async_sram_ctl_pkg::*;
#(
  parameter int RD_CYC = 9,
  parameter int SU_CYC = 4,
  parameter int WP_CYC = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  logic       reqWrite,
  output logic       ack,
  output logic       rdValid,
  output ctlStrobe_t strb
);

  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, SU_CYC), WP_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] SU_LAST = CNT_W'(SU_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);

  ctlState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             ackNext, rvNext, load, capture;
  logic             selQ, rdQ, wrQ, drvQ;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    ackNext   = 1'b0;
    rvNext    = 1'b0;
    load      = 1'b0;
    capture   = 1'b0;
    unique case (state)
      S_IDLE: begin
        // R9: new work only once the previous acknowledge has cleared
        if (req && !ack) begin
          load = 1'b1;
          if (reqWrite) begin
            stateNext = S_WSETUP;
            cntNext   = SU_LAST;
          end else begin
            stateNext = S_READ;
            cntNext   = RD_LAST;
          end
        end
      end
      S_READ: begin
        if (cnt == '0) begin
          capture   = 1'b1;
          stateNext = S_IDLE;
          ackNext   = 1'b1;
          rvNext    = 1'b1;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      S_WSETUP: begin
        if (cnt == '0) begin
          stateNext = S_WPULSE;
          cntNext   = WP_LAST;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      S_WPULSE: begin
        if (cnt == '0) stateNext = S_WEND;
        else           cntNext   = cnt - 1'b1;
      end
      S_WEND: begin
        stateNext = S_IDLE;
        ackNext   = 1'b1;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  // Pin strobes are registered from the next state so memory pins switch
  // on the same edge as the state and never glitch from decode logic.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      ack     <= 1'b0;
      rdValid <= 1'b0;
      selQ    <= 1'b0;
      rdQ     <= 1'b0;
      wrQ     <= 1'b0;
      drvQ    <= 1'b0;
    end else begin
      state   <= stateNext;
      cnt     <= cntNext;
      ack     <= ackNext;
      rdValid <= rvNext;
      selQ    <= (stateNext == S_READ) || (stateNext == S_WSETUP) ||
                 (stateNext == S_WPULSE);
      rdQ     <= (stateNext == S_READ);
      wrQ     <= (stateNext == S_WPULSE);
      drvQ    <= (stateNext == S_WPULSE);
    end
  end

  assign strb = '{load: load, capture: capture, chipSel: selQ,
                  readEn: rdQ, writeEn: wrQ, driveBus: drvQ};

endmodule

// File: rtl/async_sram_ctl_dp.sv
module async_sram_ctl_dp
  import async_sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] dqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  laneN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] rdData
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;

  // Address only moves on load, which happens in idle with write enable high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
    end else if (strb.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rdData[i*LANE_W +: LANE_W] <= '0;
      else if (strb.capture)
        rdData[i*LANE_W +: LANE_W] <= beQ[i] ? dqIn[i*LANE_W +: LANE_W] : '0;
    end
    assign laneN[i] = ~(strb.chipSel & beQ[i]);
  end

  assign memAddr = addrQ;
  assign memCeN  = ~strb.chipSel;
  assign memCe2  = strb.chipSel;
  assign memWeN  = ~strb.writeEn;
  assign memOeN  = ~strb.readEn;
  assign dqOut   = wdataQ;
  assign dqOe    = strb.driveBus;

endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
  import async_sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 85,
  parameter int T_AA_NS  = 85,
  parameter int T_OE_NS  = 40,
  parameter int T_OHZ_NS = 35,
  parameter int T_WC_NS  = 85,
  parameter int T_AW_NS  = 85,
  parameter int T_WP_NS  = 40,
  parameter int T_BW_NS  = 50,
  parameter int T_DW_NS  = 35
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqBe,
  output logic              ack,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  input  logic [DATA_W-1:0] dqIn
);

  localparam int LANES  = 2;
  localparam int RD_CYC = nsToCycles(maxOf(maxOf(T_RC_NS, T_AA_NS), T_OE_NS), CLK_NS);
  localparam int SU_CYC = nsToCycles(T_OHZ_NS, CLK_NS);
  localparam int WP_CYC = nsToCycles(maxOf(maxOf(maxOf(T_WC_NS, T_AW_NS),
                                       maxOf(T_WP_NS, T_BW_NS)), T_DW_NS), CLK_NS);

  // R10: derived counts must be usable
  if (RD_CYC < 1 || SU_CYC < 1 || WP_CYC < 1) begin : g_badTiming
    $error("async_sram_ctl: a derived cycle count is below 1");
  end
  if (DATA_W != 8 * LANES) begin : g_badWidth
    $error("async_sram_ctl: data width must be two byte lanes");
  end

  ctlStrobe_t       strb;
  logic [LANES-1:0] laneN;

  async_sram_ctl_fsm #(
    .RD_CYC(RD_CYC), .SU_CYC(SU_CYC), .WP_CYC(WP_CYC)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .req(req), .reqWrite(reqWrite),
    .ack(ack), .rdValid(rdValid), .strb(strb)
  );

  async_sram_ctl_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .dqIn(dqIn),
    .memAddr(memAddr), .memCeN(memCeN), .memCe2(memCe2),
    .memWeN(memWeN), .memOeN(memOeN), .laneN(laneN),
    .dqOut(dqOut), .dqOe(dqOe), .rdData(rdData)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[1];

endmodule

// File: rtl/async_sram_ctl_chk.sv
module async_sram_ctl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              ack,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN,
  input logic              dqOe
);

  // R4: write enable only low inside a selected cycle, with output enable off
  a_r4_we_inside_select: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memCe2 && memOeN && dqOe));

  // R4: bus driven only during the write-enable-low phase
  a_r4_drive_only_we_low: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !memWeN);

  // R2: reading never overlaps the controller driving the bus
  a_r2_oe_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !dqOe && !memCeN));

  // R6: address moves only with write enable high now and before
  a_r6_addr_we_high: assert property (@(posedge clk) disable iff (!rstN)
    (memAddr != $past(memAddr)) |-> (memWeN && $past(memWeN)));

  // R7: cycle after write enable rises is deselected
  a_r7_idle_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memCeN && !memCe2 && !dqOe));

  // R9: acknowledge is a single-cycle pulse
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  // R3: read-valid only together with acknowledge
  a_r3_valid_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ack);

  // R1: both chip enables always agree
  a_r1_enables_agree: assert property (@(posedge clk) disable iff (!rstN)
    memCeN == !memCe2);

endmodule

bind async_sram_ctl async_sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .ack(ack), .rdValid(rdValid), .memAddr(memAddr),
  .memCeN(memCeN), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
  .dqOe(dqOe)
);

// File: tb/async_sram_ctl_test.sv
module async_sram_ctl_test;

  localparam int CLK_PERIOD = 10;
  // Expected cycle counts, from the timing limits and the clock period
  localparam int EXP_RD = (85 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int EXP_SU = (35 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int EXP_WP = (85 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic        ack, rdValid;
  logic [15:0] rdData, dqOut, dqIn;
  logic [16:0] memAddr;
  logic        memCeN, memCe2, memWeN, memOeN, memLbN, memUbN, dqOe;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  async_sram_ctl uut (
    .clk(clk), .rstN(rstN), .req(req), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .ack(ack), .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memCe2(memCe2),
    .memWeN(memWeN), .memOeN(memOeN), .memLbN(memLbN), .memUbN(memUbN),
    .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pin-level memory model and protocol monitor
  bit [15:0] memArr [int];
  bit [15:0] refArr [int];
  logic [15:0] memDrive = 'z;
  assign dqIn = memDrive;

  int weLowCnt, setupCnt, readCnt, violR4, violR6, violR7, violR8;
  logic [1:0]  curBe;
  logic [16:0] prevAddr = '0;
  logic        prevWeN = 1'b1;

  function automatic bit [15:0] rdArr(input bit [15:0] arr [int], input int a);
    return arr.exists(a) ? arr[a] : 16'h0000;
  endfunction

  function automatic bit [15:0] mergeLanes(input bit [15:0] old, input bit [15:0] nw,
                                           input logic [1:0] be);
    bit [15:0] r = old;
    if (be[0]) r[7:0]  = nw[7:0];
    if (be[1]) r[15:8] = nw[15:8];
    return r;
  endfunction

  always @(negedge clk) begin
    bit sel;
    bit [15:0] cur;
    sel = !memCeN && memCe2;
    if (rstN) begin
      if (sel && !memWeN) begin
        weLowCnt++;
        if (!dqOe) violR4++;
        cur = rdArr(memArr, int'(memAddr));
        if (!memLbN) cur[7:0]  = dqOut[7:0];
        if (!memUbN) cur[15:8] = dqOut[15:8];
        memArr[int'(memAddr)] = cur;
      end
      if (dqOe && memWeN) violR4++;
      if (sel && memWeN && memOeN) begin
        setupCnt++;
        if (dqOe) violR4++;
      end
      if (sel && !memOeN) readCnt++;
      if (sel && ({memUbN, memLbN} != ~curBe)) violR8++;
      if (memAddr != prevAddr && (!memWeN || !prevWeN)) violR6++;
      if (!prevWeN && memWeN && (sel || dqOe)) violR7++;
      if (dqOe && sel && memWeN && !memOeN) violR4++;
    end
    prevAddr = memAddr;
    prevWeN  = memWeN;
    if (sel && memWeN && !memOeN) begin
      cur = rdArr(memArr, int'(memAddr));
      memDrive[7:0]  = !memLbN ? cur[7:0]  : 8'hzz;
      memDrive[15:8] = !memUbN ? cur[15:8] : 8'hzz;
    end else begin
      memDrive = 'z;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic checkIdle(input string rq);
    check(memCeN && !memCe2 && memWeN && memOeN && !dqOe && !ack && !rdValid,
          rq, "idle pins {ceN,ce2,weN,oeN,oe,ack,rv}",
          {memCeN, memCe2, memWeN, memOeN, dqOe, ack, rdValid}, 7'b1011000);
  endtask

  task automatic doAccess(input bit wr, input logic [16:0] a,
                          input logic [15:0] d, input logic [1:0] be);
    int lat = 0;
    bit earlyRv = 1'b0;
    bit [15:0] expRd;
    @(negedge clk);
    weLowCnt = 0; setupCnt = 0; readCnt = 0;
    violR4 = 0; violR6 = 0; violR7 = 0; violR8 = 0;
    curBe = be;
    req = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    do begin
      @(negedge clk);
      lat++;
      if (rdValid && !ack) earlyRv = 1'b1;
    end while (!ack && lat < 100);
    req = 1'b0;
    #1;
    if (wr) begin
      refArr[int'(a)] = mergeLanes(rdArr(refArr, int'(a)), d, be);
      check(lat == EXP_SU + EXP_WP + 2, "R5", "write ack latency", lat, EXP_SU + EXP_WP + 2);
      check(weLowCnt == EXP_WP && violR4 == 0, "R4", "we-low cycles / drive violations",
            weLowCnt * 256 + violR4, EXP_WP * 256);
      check(setupCnt == EXP_SU, "R5", "setup cycles", setupCnt, EXP_SU);
      check(!rdValid && !earlyRv, "R3", "read-valid on write", rdValid, 0);
      check(violR7 == 0, "R7", "idle after write", violR7, 0);
    end else begin
      expRd = rdArr(refArr, int'(a));
      if (!be[0]) expRd[7:0]  = 8'h00;
      if (!be[1]) expRd[15:8] = 8'h00;
      check(lat == EXP_RD + 1, "R2", "read ack latency", lat, EXP_RD + 1);
      check(readCnt == EXP_RD, "R2", "output-enable cycles", readCnt, EXP_RD);
      check(rdValid && !earlyRv, "R3", "read-valid with ack", rdValid, 1);
      check(rdData == expRd, "R8", "read data lanes", rdData, expRd);
    end
    check(violR6 == 0, "R6", "address moved with we low", violR6, 0);
    check(violR8 == 0, "R8", "lane strobe vs enable", violR8, 0);
    // R1 and R9: with req dropped, the pulse ends and no new access starts
    @(negedge clk);
    checkIdle("R1/R9");
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    curBe = 2'b00;
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1");

    // Directed corner cases
    doAccess(1'b1, 17'h00000, 16'hA55A, 2'b11);
    doAccess(1'b0, 17'h00000, 16'h0000, 2'b11);
    doAccess(1'b1, 17'h1FFFF, 16'h1234, 2'b11);
    doAccess(1'b1, 17'h1FFFF, 16'hFFEE, 2'b01);   // R8 low lane only
    doAccess(1'b0, 17'h1FFFF, 16'h0000, 2'b11);
    doAccess(1'b1, 17'h1FFFF, 16'h9900, 2'b10);   // R8 high lane only
    doAccess(1'b0, 17'h1FFFF, 16'h0000, 2'b01);   // R8 masked read
    doAccess(1'b1, 17'h00000, 16'hDEAD, 2'b00);   // R8 no lane written
    doAccess(1'b0, 17'h00000, 16'h0000, 2'b11);
    doAccess(1'b0, 17'h00000, 16'h0000, 2'b00);   // R8 no lane read

    // Random mix over a small address pool
    for (int i = 0; i < 60; i++) begin
      logic [16:0] a;
      a = 17'h0A5C0 | 17'($urandom % 8);
      doAccess(1'($urandom), a, 16'($urandom), 2'($urandom));
    end

    done = 1'b1;
    finishRun();
  end

endmodule